// File: doc/BRIEF.md
# Retired-Store Buffer with Selectable Drain Ordering

This block sits between a processor core and memory. It holds retired stores until memory accepts them, so the core does not wait for each write to finish. Loads are looked up against the held stores in the same cycle. A load that finds a held store to its address gets that data at once. A load that finds none is reported as a miss and may go to memory ahead of the older stores.

A mode input picks the drain policy. In the in-order policy, writes leave in exactly the order their stores arrived, and two stores to one address each keep a slot of their own. In the relaxed policy, the lowest-numbered occupied slot drains first, and a new store to an address already held in a slot that is not being written folds its data into that slot. A fence request closes both the store and the load port until every held store has been acknowledged. Completion of the fence is signalled by a single-cycle done pulse.

Memory sees a single write port. At most one write is outstanding on it, and a slot is released only in the cycle its acknowledge arrives.

Top module: `store_buf`

## Requirements
- R1: After reset the buffer is empty: `stReady` is 1, `memValid` is 0, `fenceDone` is 0 and `ldHit` is 0.
- R2: With no fence pending, `ldReady` is 1 even while stores are held, and a load whose address matches no held store returns `ldHit` = 0 in the same cycle.
- R3: A load whose address matches one or more held stores returns `ldHit` = 1 and the data of the youngest matching store, combinationally and without a memory access.
- R4: With `modePso` = 0, memory writes occur in the order the stores were accepted, and a store to an address already held takes a new slot, so both writes reach memory.
- R5: A store that is accepted and not merged takes the lowest-numbered free slot. With `modePso` = 1, when the write port is idle the lowest-numbered occupied slot is written next, so a younger store in a low slot can reach memory before an older store in a higher slot.
- R6: With `modePso` = 1, a store whose address matches a held slot that is not the write in flight overwrites that slot's data and takes no new slot. Such a store is accepted even when every slot is occupied.
- R7: When all slots are occupied and R6 does not apply, `stReady` is 0.
- R8: At most one write is outstanding. `memValid` rises in the cycle after a held slot becomes eligible while the port is idle. `memAddr` and `memData` stay constant until the cycle `memAck` is sampled high, and that slot is freed at that same edge.
- R9: A `fenceReq` sampled high makes `stReady` and `ldReady` 0 from the next cycle. Once no slot is held and no write is outstanding, `fenceDone` is 1 for exactly one cycle, after which both ports reopen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modePso | input | 1 | 0 = in-order drain, 1 = relaxed drain with merging |
| stValid | input | 1 | Store offered |
| stReady | output | 1 | Store accepted at this edge when high together with stValid |
| stAddr | input | ADDR_W | Store address |
| stData | input | DATA_W | Store data |
| ldValid | input | 1 | Load lookup request |
| ldReady | output | 1 | Load port open (low while a fence is pending) |
| ldAddr | input | ADDR_W | Load address |
| ldHit | output | 1 | Load address matches a held store |
| ldData | output | DATA_W | Youngest matching store data (valid when ldHit) |
| memValid | output | 1 | Write to memory outstanding |
| memAddr | output | ADDR_W | Write address |
| memData | output | DATA_W | Write data |
| memAck | input | 1 | Memory accepts the outstanding write |
| fenceReq | input | 1 | Fence request, sampled while no fence is pending |
| fenceDone | output | 1 | One-cycle pulse when the fence completes |

## Verification
The bench builds the block with its default four slots, a 16-bit address and 32-bit data. Four slots are few enough that a short burst of stores fills the buffer. That makes the full-stall case and the full-but-merging case reachable within a few cycles. The bench also varies the acknowledge latency. A long latency keeps one write in flight while a freed low slot is refilled, which is the only way the relaxed drain order can diverge from arrival order, and it also exercises the rule that a merge never targets the write in flight.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int IDX_W = 2;
  localparam int DEPTH = 1 << IDX_W;

  typedef logic [IDX_W-1:0] idx_t;

  typedef enum logic {
    ORD_TOTAL   = 1'b0,
    ORD_PARTIAL = 1'b1
  } ord_e;

  // strobes from control to the slot array
  typedef struct packed {
    logic allocEn;
    idx_t allocIdx;
    idx_t allocAge;
    logic mergeEn;
    idx_t mergeIdx;
    logic retireEn;
    idx_t retireIdx;
    idx_t ldSel;
    idx_t rdIdx;
  } ctl_t;
endpackage

// File: rtl/sbuf_data.sv
module sbuf_data
  import sbuf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctl_t                        ctl,
  input  logic [ADDR_W-1:0]           stAddr,
  input  logic [DATA_W-1:0]           stData,
  input  logic [ADDR_W-1:0]           ldAddr,
  output logic [DEPTH-1:0]            validVec,
  output logic [DEPTH-1:0]            stMatchVec,
  output logic [DEPTH-1:0]            ldMatchVec,
  output logic [DEPTH-1:0][IDX_W-1:0] ageArr,
  output logic [DATA_W-1:0]           ldData,
  output logic [ADDR_W-1:0]           rdAddr,
  output logic [DATA_W-1:0]           rdData
);
  logic [DEPTH-1:0][ADDR_W-1:0] addrArr;
  logic [DEPTH-1:0][DATA_W-1:0] dataArr;
  idx_t retireAge;

  assign retireAge = ageArr[ctl.retireIdx];

  // slot storage; age 0 is the oldest held store
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec <= '0;
      ageArr   <= '0;
      addrArr  <= '0;
      dataArr  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ctl.retireEn && validVec[i] && (ageArr[i] > retireAge))
          ageArr[i] <= ageArr[i] - 1'b1;
        if (ctl.retireEn && (ctl.retireIdx == idx_t'(i)))
          validVec[i] <= 1'b0;
        if (ctl.allocEn && (ctl.allocIdx == idx_t'(i))) begin
          validVec[i] <= 1'b1;
          addrArr[i]  <= stAddr;
          dataArr[i]  <= stData;
          ageArr[i]   <= ctl.allocAge;
        end
        if (ctl.mergeEn && (ctl.mergeIdx == idx_t'(i)))
          dataArr[i] <= stData;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gCmp
    assign stMatchVec[g] = validVec[g] && (addrArr[g] == stAddr);
    assign ldMatchVec[g] = validVec[g] && (addrArr[g] == ldAddr);
  end

  assign ldData = dataArr[ctl.ldSel];
  assign rdAddr = addrArr[ctl.rdIdx];
  assign rdData = dataArr[ctl.rdIdx];
endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
  import sbuf_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        modePso,
  input  logic                        stValid,
  input  logic                        ldValid,
  input  logic                        memAck,
  input  logic                        fenceReq,
  input  logic [DEPTH-1:0]            validVec,
  input  logic [DEPTH-1:0]            stMatchVec,
  input  logic [DEPTH-1:0]            ldMatchVec,
  input  logic [DEPTH-1:0][IDX_W-1:0] ageArr,
  output ctl_t                        ctl,
  output logic                        stReady,
  output logic                        ldReady,
  output logic                        ldHit,
  output logic                        memValid,
  output logic                        fenceDone
);
  localparam int CNT_W = IDX_W + 1;

  ord_e       ordMode;
  logic       inflight;
  idx_t       infIdx;
  logic       fenceActive;
  logic [CNT_W-1:0] count;
  idx_t       freeIdx, lowIdx, oldIdx, ldBest, mergeIdx, issueIdx;
  idx_t       ldBestAge, mergeAge;
  logic       ldAny, mergeHit;
  logic       accept, doMerge, doAlloc, doIssue, doRetire;

  assign ordMode = ord_e'(modePso);

  always_comb begin
    count = '0;
    for (int i = 0; i < DEPTH; i++)
      count = count + CNT_W'(validVec[i]);

    freeIdx = '0;
    lowIdx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!validVec[i]) freeIdx = idx_t'(i);
      if (validVec[i])  lowIdx  = idx_t'(i);
    end

    oldIdx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (validVec[i] && (ageArr[i] == '0)) oldIdx = idx_t'(i);

    ldAny = 1'b0;
    ldBest = '0;
    ldBestAge = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ldMatchVec[i] && (!ldAny || (ageArr[i] > ldBestAge))) begin
        ldAny = 1'b1;
        ldBest = idx_t'(i);
        ldBestAge = ageArr[i];
      end
    end

    mergeHit = 1'b0;
    mergeIdx = '0;
    mergeAge = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (stMatchVec[i] && !(inflight && (infIdx == idx_t'(i))) &&
          (!mergeHit || (ageArr[i] > mergeAge))) begin
        mergeHit = 1'b1;
        mergeIdx = idx_t'(i);
        mergeAge = ageArr[i];
      end
    end
    if (ordMode != ORD_PARTIAL) mergeHit = 1'b0;
  end

  assign stReady = !fenceActive && ((count < CNT_W'(DEPTH)) || mergeHit);
  assign ldReady = !fenceActive;
  assign ldHit   = ldValid && ldReady && ldAny;

  assign accept   = stValid && stReady;
  assign doMerge  = accept && mergeHit;
  assign doAlloc  = accept && !mergeHit;
  assign doRetire = inflight && memAck;
  assign doIssue  = !inflight && (count != '0);
  assign issueIdx = (ordMode == ORD_PARTIAL) ? lowIdx : oldIdx;

  assign fenceDone = fenceActive && (count == '0) && !inflight;
  assign memValid  = inflight;

  always_comb begin
    ctl = '0;
    ctl.allocEn   = doAlloc;
    ctl.allocIdx  = freeIdx;
    ctl.allocAge  = idx_t'(count - CNT_W'(doRetire));
    ctl.mergeEn   = doMerge;
    ctl.mergeIdx  = mergeIdx;
    ctl.retireEn  = doRetire;
    ctl.retireIdx = infIdx;
    ctl.ldSel     = ldBest;
    ctl.rdIdx     = infIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inflight    <= 1'b0;
      infIdx      <= '0;
      fenceActive <= 1'b0;
    end else begin
      if (doRetire) begin
        inflight <= 1'b0;
      end else if (doIssue) begin
        inflight <= 1'b1;
        infIdx   <= issueIdx;
      end
      if (fenceDone)
        fenceActive <= 1'b0;
      else if (fenceReq)
        fenceActive <= 1'b1;
    end
  end
endmodule

// File: rtl/store_buf.sv
module store_buf
  import sbuf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modePso,
  input  logic              stValid,
  output logic              stReady,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic              ldValid,
  output logic              ldReady,
  input  logic [ADDR_W-1:0] ldAddr,
  output logic              ldHit,
  output logic [DATA_W-1:0] ldData,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  input  logic              memAck,
  input  logic              fenceReq,
  output logic              fenceDone
);
  ctl_t                        ctl;
  logic [DEPTH-1:0]            validVec, stMatchVec, ldMatchVec;
  logic [DEPTH-1:0][IDX_W-1:0] ageArr;

  sbuf_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .modePso(modePso), .stValid(stValid),
    .ldValid(ldValid), .memAck(memAck), .fenceReq(fenceReq),
    .validVec(validVec), .stMatchVec(stMatchVec), .ldMatchVec(ldMatchVec),
    .ageArr(ageArr), .ctl(ctl), .stReady(stReady), .ldReady(ldReady),
    .ldHit(ldHit), .memValid(memValid), .fenceDone(fenceDone)
  );

  sbuf_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) data_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stAddr(stAddr), .stData(stData),
    .ldAddr(ldAddr), .validVec(validVec), .stMatchVec(stMatchVec),
    .ldMatchVec(ldMatchVec), .ageArr(ageArr), .ldData(ldData),
    .rdAddr(memAddr), .rdData(memData)
  );
endmodule

// File: rtl/sbuf_chk.sv
module sbuf_chk
  import sbuf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              modePso,
  input logic              stReady,
  input logic              ldReady,
  input logic              ldHit,
  input logic              memValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memData,
  input logic              memAck,
  input logic              fenceDone,
  input logic [DEPTH-1:0]  validVec
);
  AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memAck |=> memValid && $stable(memAddr) && $stable(memData)); // R8
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (&validVec) && !modePso |-> !stReady); // R7
  AST_FENCE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    fenceDone |-> !memValid && (validVec == '0)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    fenceDone |=> !fenceDone); // R9
  AST_FENCE_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    fenceDone |-> !stReady && !ldReady); // R9
  AST_HIT_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    ldHit |-> (validVec != '0)); // R3
endmodule

bind store_buf sbuf_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .modePso(modePso), .stReady(stReady),
  .ldReady(ldReady), .ldHit(ldHit), .memValid(memValid), .memAddr(memAddr),
  .memData(memData), .memAck(memAck), .fenceDone(fenceDone),
  .validVec(validVec)
);

// File: tb/store_buf_tb_top.sv
`timescale 1ns/1ps
module store_buf_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NSLOT = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic modePso = 1'b0, stValid = 1'b0, ldValid = 1'b0, memAck = 1'b0, fenceReq = 1'b0;
  logic [AW-1:0] stAddr = '0, ldAddr = '0;
  logic [DW-1:0] stData = '0;
  logic stReady, ldReady, ldHit, memValid, fenceDone;
  logic [DW-1:0] ldData, memData;
  logic [AW-1:0] memAddr;

  store_buf #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .modePso(modePso), .stValid(stValid), .stReady(stReady),
    .stAddr(stAddr), .stData(stData), .ldValid(ldValid), .ldReady(ldReady),
    .ldAddr(ldAddr), .ldHit(ldHit), .ldData(ldData), .memValid(memValid),
    .memAddr(memAddr), .memData(memData), .memAck(memAck), .fenceReq(fenceReq),
    .fenceDone(fenceDone)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0, ackLat = 1, waitCnt = 0;
  logic [AW-1:0] logA[$];
  logic [DW-1:0] logD[$];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: slot contents plus an age-ordered list of slots
  bit            mV[NSLOT];
  logic [AW-1:0] mA[NSLOT];
  logic [DW-1:0] mD[NSLOT];
  int            ordQ[$];
  bit            mInf, mFa;
  int            mInfIdx;

  task automatic modelStep();
    int cnt, mIdx, lIdx, fIdx, lowV, iIdx;
    bit eStR, eHit, eDone, acc, ret, iss;
    cnt = ordQ.size();
    mIdx = -1;
    if (modePso)
      for (int k = cnt - 1; k >= 0; k--)
        if (mA[ordQ[k]] == stAddr && !(mInf && mInfIdx == ordQ[k])) begin mIdx = ordQ[k]; break; end
    lIdx = -1;
    for (int k = cnt - 1; k >= 0; k--)
      if (mA[ordQ[k]] == ldAddr) begin lIdx = ordQ[k]; break; end
    eStR  = !mFa && (cnt < NSLOT || mIdx >= 0);
    eHit  = ldValid && !mFa && lIdx >= 0;
    eDone = mFa && cnt == 0 && !mInf;
    chk(stReady == eStR, "R7", "stReady", stReady, eStR);
    chk(ldReady == !mFa, "R9", "ldReady", ldReady, !mFa);
    chk(ldHit == eHit, "R3", "ldHit", ldHit, eHit);
    if (eHit) chk(ldData == mD[lIdx], "R3", "ldData", ldData, mD[lIdx]);
    chk(memValid == mInf, "R8", "memValid", memValid, mInf);
    if (mInf) begin
      chk(memAddr == mA[mInfIdx], "R4", "memAddr", memAddr, mA[mInfIdx]);
      chk(memData == mD[mInfIdx], "R4", "memData", memData, mD[mInfIdx]);
    end
    chk(fenceDone == eDone, "R9", "fenceDone", fenceDone, eDone);
    // next state from the pre-edge view
    fIdx = -1; lowV = -1;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!mV[i]) fIdx = i;
      if (mV[i]) lowV = i;
    end
    acc = stValid && eStR;
    ret = mInf && memAck;
    iss = !mInf && cnt > 0;
    iIdx = modePso ? lowV : (cnt > 0 ? ordQ[0] : 0);
    if (ret) begin
      mV[mInfIdx] = 1'b0;
      for (int k = 0; k < ordQ.size(); k++)
        if (ordQ[k] == mInfIdx) begin ordQ.delete(k); break; end
      mInf = 1'b0;
    end else if (iss) begin
      mInf = 1'b1; mInfIdx = iIdx;
    end
    if (acc) begin
      if (mIdx >= 0) mD[mIdx] = stData;
      else begin
        mV[fIdx] = 1'b1; mA[fIdx] = stAddr; mD[fIdx] = stData; ordQ.push_back(fIdx);
      end
    end
    if (eDone) mFa = 1'b0;
    else if (fenceReq) mFa = 1'b1;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (!rstN) begin
        for (int i = 0; i < NSLOT; i++) begin mV[i] = 0; mA[i] = '0; mD[i] = '0; end
        ordQ.delete(); mInf = 0; mFa = 0; mInfIdx = 0;
      end else modelStep();
    end
  end

  // memory responder with adjustable acknowledge latency
  initial begin
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck = 1'b0; waitCnt = 0;
      end else if (rstN && memValid) begin
        waitCnt++;
        if (waitCnt >= ackLat) begin
          memAck = 1'b1; logA.push_back(memAddr); logD.push_back(memData);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        chk(1'b0, "watchdog", "cycle limit", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  // tasks start and end at a falling edge
  task automatic doStore(logic [AW-1:0] a, logic [DW-1:0] d);
    stValid = 1'b1; stAddr = a; stData = d;
    forever begin #1; if (stReady) break; @(negedge clk); end
    @(negedge clk);
    stValid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doLoad(logic [AW-1:0] a, bit eHit, logic [DW-1:0] eData, string req);
    ldValid = 1'b1; ldAddr = a;
    #2;
    chk(ldHit == eHit, req, "load hit", ldHit, eHit);
    if (eHit) chk(ldData == eData, req, "load data", ldData, eData);
    @(negedge clk);
    ldValid = 1'b0;
  endtask

  task automatic waitLog(int n);
    while (logA.size() < n) @(negedge clk);
  endtask

  task automatic drain();
    while (memValid || logA.size() == 0 || ordQ.size() != 0) begin
      if (!memValid && ordQ.size() == 0) break;
      @(negedge clk);
    end
    idle(2);
  endtask

  task automatic orderRun(bit pso, string req, logic [AW-1:0] exp3);
    logA.delete(); logD.delete();
    modePso = pso; ackLat = 4;
    doStore(16'h0010, 32'hA);
    doStore(16'h0020, 32'hB);
    doStore(16'h0030, 32'hC);
    waitLog(1);
    idle(1);
    doStore(16'h0040, 32'hD);
    waitLog(4);
    idle(3);
    chk(logA[0] == 16'h0010 && logA[1] == 16'h0020, req, "first writes", logA[1], 16'h0020);
    chk(logA[2] == exp3, req, "third write addr", logA[2], exp3);
  endtask

  initial begin
    idle(2);
    rstN = 1'b1;
    #2;
    chk(stReady == 1 && memValid == 0 && fenceDone == 0 && ldHit == 0, "R1", "reset outputs",
        {stReady, memValid, fenceDone, ldHit}, 4'b1000);
    @(negedge clk);

    // R2, R3, R4: in-order mode, same address twice
    modePso = 1'b0; ackLat = 6;
    doStore(16'h0100, 32'h1111);
    doStore(16'h0100, 32'h2222);
    doLoad(16'h0100, 1'b1, 32'h2222, "R3");
    doLoad(16'h0200, 1'b0, '0, "R2");
    chk(ldReady == 1'b1, "R2", "load port open with stores held", ldReady, 1);
    waitLog(2);
    idle(2);
    chk(logD[0] == 32'h1111 && logD[1] == 32'h2222, "R4", "same-address writes kept apart", logD[1], 32'h2222);

    // R5/R4: drain order, relaxed vs in-order
    orderRun(1'b1, "R5", 16'h0040);
    orderRun(1'b0, "R4", 16'h0030);

    // R6: merge skips the write in flight
    logA.delete(); logD.delete();
    modePso = 1'b1; ackLat = 6;
    doStore(16'h0300, 32'h5);
    idle(2);
    doStore(16'h0300, 32'h6);
    doStore(16'h0300, 32'h7);
    waitLog(2);
    idle(8);
    chk(logA.size() == 2, "R6", "write count after merge", logA.size(), 2);
    chk(logD[0] == 32'h5 && logD[1] == 32'h7, "R6", "merged data", logD[1], 32'h7);

    // R7 full stall, then R6 merge accepted while full
    logA.delete(); logD.delete();
    modePso = 1'b0; ackLat = 30;
    for (int i = 0; i < NSLOT; i++) doStore(16'h0400 + 16'(i), 32'h40 + 32'(i));
    stValid = 1'b1; stAddr = 16'h0500; stData = 32'h99;
    #2;
    chk(stReady == 1'b0, "R7", "stReady when full", stReady, 0);
    @(negedge clk);
    stValid = 1'b0;
    modePso = 1'b1;
    doStore(16'h0402, 32'hEE);
    waitLog(4);
    idle(3);
    chk(logA.size() == 4, "R6", "no extra slot on merge", logA.size(), 4);
    chk(logA[2] == 16'h0402 && logD[2] == 32'hEE, "R6", "merged slot data", logD[2], 32'hEE);

    // R9 fence
    modePso = 1'b0; ackLat = 3;
    doStore(16'h0600, 32'h61);
    doStore(16'h0601, 32'h62);
    fenceReq = 1'b1;
    @(negedge clk);
    fenceReq = 1'b0;
    #2;
    chk(stReady == 1'b0 && ldReady == 1'b0, "R9", "ports closed by fence", {stReady, ldReady}, 0);
    begin
      int pulse = 0;
      while (!fenceDone) @(negedge clk);
      while (fenceDone) begin pulse++; @(negedge clk); #2; end
      chk(pulse == 1, "R9", "done pulse width", pulse, 1);
    end
    chk(stReady == 1'b1 && ldReady == 1'b1 && memValid == 1'b0, "R9", "ports reopen", {stReady, ldReady}, 2'b11);
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule